// File: doc/BRIEF.md
# I2C Bus Protocol Monitor

A passive watcher for a two-wire I2C bus. It samples the clock and data lines with a much faster system clock and drives nothing on the bus. Each line first passes through a synchronizer. The block then decodes start, repeated start and stop conditions. It builds each data byte from the clock's rising edges and captures the acknowledge bit on the ninth clock. It also flags any data-line movement during a clock-high phase that is not a legal condition.

Every bus event comes out as a one-cycle strobe. A completed byte is presented with its value and its acknowledge bit. A protocol error raises a flag that stays set until reset. A level output shows when no transfer is in progress and both lines are high. The block is meant to sit beside a bus master or slave, or on a debug port, to log traffic and catch malformed waveforms.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset all strobes and the error flag are low, and the idle output is high while both lines are high.
- R2: A falling data line while the clock is high, with no transfer active, gives one `evt_start` pulse. The pulse comes 3 system cycles after the line change with the default two synchronizer stages. It marks a transfer as active.
- R3: A falling data line while the clock is high during an active transfer, at the first clock of a byte, gives `evt_rep_start` instead of `evt_start`. The next byte is then decoded from bit zero.
- R4: A rising data line while the clock is high, at the first clock of a byte or with no transfer active, gives one `evt_stop` pulse. The transfer ends, and the idle output is high once both lines are high.
- R5: Data bits are sampled on rising clock edges, most significant bit first, and a high line is 1.
- R6: The ninth clock carries the acknowledge bit, reported on `byte_ack` as 0 for acknowledge (line low) and 1 for no acknowledge (line high). `byte_valid` pulses once on the falling clock edge after that ninth bit, with `byte_data` and `byte_ack`.
- R7: A data-line change while the clock is high, after two to nine clocks of the current byte, sets `proto_err`. Only reset clears it. Such a change is not reported as a start or stop.
- R8: The strobes `evt_start`, `evt_rep_start`, `evt_stop` and `byte_valid` each last one cycle, and no two are high at once.
- R9: Clock pulses seen while no transfer is active produce no `byte_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Observed bus clock line |
| sda_in | input | 1 | Observed bus data line |
| evt_start | output | 1 | Start condition strobe |
| evt_rep_start | output | 1 | Repeated start strobe |
| evt_stop | output | 1 | Stop condition strobe |
| byte_valid | output | 1 | Completed byte strobe |
| byte_data | output | 8 | Byte value, first bit in the MSB |
| byte_ack | output | 1 | Acknowledge bit of the byte, 0 = ACK |
| proto_err | output | 1 | Sticky protocol violation flag |
| bus_idle | output | 1 | No transfer active and both lines high |

## Verification
The assertions assume that each bus line holds its level for at least a few system cycles between changes. Under that assumption a stop strobe finds both lines still high, so the idle output is already set, and a condition is never split across samples. The bench drives the bus in quarter-bit phases of six system cycles, changing one line at a time. It never moves the two lines in the same cycle, so every checked property sits well inside that assumption.

// File: rtl/i2cmon_pkg.sv
// Shared types for the bus monitor: the per-sample view of both lines.
package i2cmon_pkg;

    // Synchronized levels and edge markers for the clock and data lines.
    typedef struct packed {
        logic scl_now;   // synchronized clock level
        logic scl_old;   // clock level one sample earlier
        logic sda_now;   // synchronized data level
        logic sda_rise;  // data went low to high
        logic sda_fall;  // data went high to low
        logic scl_rise;  // clock went low to high
        logic scl_fall;  // clock went high to low
    } line_view_t;

endpackage

// File: rtl/i2cmon_sync.sv
// Line synchronizer and edge finder.
// Each raw bus line passes through SYNC_STAGES flops. One more flop keeps the
// previous synchronized value so that edges are seen on synchronized data.
// Assumes the raw lines are asynchronous to clk; reset value is the released
// (high) level of an open-drain bus.
module i2cmon_sync
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_raw,
    input  logic       sda_raw,
    output line_view_t view
);
    localparam int CHAIN_W = SYNC_STAGES + 1;
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_bus;
    logic [N_LINES-1:0] lvl_now;
    logic [N_LINES-1:0] lvl_old;

    assign raw_bus = {sda_raw, scl_raw};

    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_line
            logic [CHAIN_W-1:0] chain;

            // Shift the raw line through the synchronizer and history flop.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[CHAIN_W-2:0], raw_bus[g]};
                end
            end

            assign lvl_now[g] = chain[SYNC_STAGES-1];
            assign lvl_old[g] = chain[SYNC_STAGES];
        end
    endgenerate

    // Assemble the line view from current and previous synchronized levels.
    always_comb begin
        view.scl_now  = lvl_now[0];
        view.scl_old  = lvl_old[0];
        view.sda_now  = lvl_now[1];
        view.sda_rise = lvl_now[1] & ~lvl_old[1];
        view.sda_fall = ~lvl_now[1] & lvl_old[1];
        view.scl_rise = lvl_now[0] & ~lvl_old[0];
        view.scl_fall = ~lvl_now[0] & lvl_old[0];
    end

endmodule

// File: rtl/i2cmon_cond.sv
// Condition classifier.
// Looks at data-line edges inside a clock-high phase. A change counts as a
// start or stop only when at most one clock of the current byte has been
// sampled; later in the byte it is a protocol violation. Start/stop detect
// outputs are combinational for the framer; event strobes and the error flag
// are registered. Assumes the clock was high in both compared samples.
module i2cmon_cond
    import i2cmon_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  line_view_t       view,
    input  logic             xfer_active,
    input  logic [CNT_W-1:0] bit_cnt,
    output logic             start_hit,
    output logic             stop_hit,
    output logic             start_o,
    output logic             rstart_o,
    output logic             stop_o,
    output logic             err_o
);
    logic clk_held_high;
    logic legal_slot;
    logic sda_moved;
    logic violation;

    // Decide whether a data edge is a condition or a violation.
    always_comb begin
        clk_held_high = view.scl_now & view.scl_old;
        legal_slot    = (bit_cnt <= CNT_W'(1));
        sda_moved     = view.sda_rise | view.sda_fall;
        start_hit     = clk_held_high & view.sda_fall & legal_slot;
        stop_hit      = clk_held_high & view.sda_rise & legal_slot;
        violation     = clk_held_high & sda_moved & ~legal_slot;
    end

    // Register the event strobes, splitting start by transfer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o  <= 1'b0;
            rstart_o <= 1'b0;
            stop_o   <= 1'b0;
        end else begin
            start_o  <= start_hit & ~xfer_active;
            rstart_o <= start_hit & xfer_active;
            stop_o   <= stop_hit;
        end
    end

    // Hold the error flag once any violation is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (violation) begin
            err_o <= 1'b1;
        end
    end

endmodule

// File: rtl/i2cmon_framer.sv
// Byte framer.
// Tracks whether a transfer is active, counts clocks within a byte, shifts
// data bits in MSB first on rising clock edges, takes the acknowledge on the
// clock after the last data bit and emits the byte on the following falling
// clock edge. A start or stop resets the count. Clocks outside a transfer
// are ignored.
module i2cmon_framer
    import i2cmon_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_view_t        view,
    input  logic              start_hit,
    input  logic              stop_hit,
    output logic              xfer_active,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              valid_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              ack_o
);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_TAKEN = CNT_W'(BYTE_W + 1);

    logic [BYTE_W-1:0] shreg;
    logic              ack_bit;

    // Transfer state and clock count within the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_active <= 1'b0;
            bit_cnt     <= '0;
        end else if (start_hit) begin
            xfer_active <= 1'b1;
            bit_cnt     <= '0;
        end else if (stop_hit) begin
            xfer_active <= 1'b0;
            bit_cnt     <= '0;
        end else if (xfer_active) begin
            if (view.scl_rise && bit_cnt <= LAST_DATA) begin
                bit_cnt <= bit_cnt + CNT_W'(1);
            end else if (view.scl_fall && bit_cnt == ACK_TAKEN) begin
                bit_cnt <= '0;
            end
        end
    end

    // Capture data bits and the acknowledge bit on rising clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            ack_bit <= 1'b0;
        end else if (xfer_active && view.scl_rise && !start_hit && !stop_hit) begin
            if (bit_cnt < LAST_DATA) begin
                shreg <= {shreg[BYTE_W-2:0], view.sda_now};
            end else if (bit_cnt == LAST_DATA) begin
                ack_bit <= view.sda_now;
            end
        end
    end

    // Emit the completed byte on the falling edge closing the ack clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            ack_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (xfer_active && view.scl_fall && bit_cnt == ACK_TAKEN
                && !start_hit && !stop_hit) begin
                valid_o <= 1'b1;
                data_o  <= shreg;
                ack_o   <= ack_bit;
            end
        end
    end

endmodule

// File: rtl/i2c_bus_monitor.sv
// Passive I2C bus monitor top.
// Wires the synchronizer, condition classifier and byte framer together and
// derives the idle level. Drives nothing on the bus. Assumes both lines hold
// each level for at least a few clk cycles.
module i2c_bus_monitor
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              evt_start,
    output logic              evt_rep_start,
    output logic              evt_stop,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_ack,
    output logic              proto_err,
    output logic              bus_idle
);
    localparam int CNT_W = $clog2(BYTE_W + 2);

    line_view_t       view;
    logic             start_hit;
    logic             stop_hit;
    logic             xfer_active;
    logic [CNT_W-1:0] bit_cnt;

    i2cmon_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .view    (view)
    );

    i2cmon_cond #(
        .CNT_W (CNT_W)
    ) u_cond (
        .clk         (clk),
        .rst_n       (rst_n),
        .view        (view),
        .xfer_active (xfer_active),
        .bit_cnt     (bit_cnt),
        .start_hit   (start_hit),
        .stop_hit    (stop_hit),
        .start_o     (evt_start),
        .rstart_o    (evt_rep_start),
        .stop_o      (evt_stop),
        .err_o       (proto_err)
    );

    i2cmon_framer #(
        .BYTE_W (BYTE_W),
        .CNT_W  (CNT_W)
    ) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .view        (view),
        .start_hit   (start_hit),
        .stop_hit    (stop_hit),
        .xfer_active (xfer_active),
        .bit_cnt     (bit_cnt),
        .valid_o     (byte_valid),
        .data_o      (byte_data),
        .ack_o       (byte_ack)
    );

    // Idle: no transfer in progress and both lines released.
    assign bus_idle = ~xfer_active & view.scl_now & view.sda_now;

endmodule

// File: rtl/i2cmon_checker.sv
// Property checker for the bus monitor, bound onto every instance.
// Assumes bus lines hold each level for several clk cycles.
module i2cmon_checker (
    input logic clk,
    input logic rst_n,
    input logic evt_start,
    input logic evt_rep_start,
    input logic evt_stop,
    input logic byte_valid,
    input logic proto_err,
    input logic bus_idle
);
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_start, evt_rep_start, evt_stop, byte_valid})); // R8
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_start |=> !evt_start); // R8
    AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_start |-> !bus_idle); // R2
    AST_RSTART_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rep_start |-> !bus_idle); // R3
    AST_STOP_GIVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stop |-> bus_idle); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R7
endmodule

bind i2c_bus_monitor i2cmon_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_start     (evt_start),
    .evt_rep_start (evt_rep_start),
    .evt_stop      (evt_stop),
    .byte_valid    (byte_valid),
    .proto_err     (proto_err),
    .bus_idle      (bus_idle)
);

// File: tb/sim_i2c_bus_monitor.sv
module sim_i2c_bus_monitor;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic evt_start, evt_rep_start, evt_stop, byte_valid, byte_ack, proto_err, bus_idle;
    logic [7:0] byte_data;

    int n_run = 0, n_fail = 0;
    int pcyc = 0;
    int got_start = 0, got_rep = 0, got_stop = 0, got_n = 0;
    int exp_start = 0, exp_rep = 0, exp_stop = 0, exp_n = 0;
    int last_start_cyc = 0, multi = 0, doubles = 0;
    logic [7:0] got_d [0:255];
    logic       got_a [0:255];
    logic [7:0] exp_d [0:255];
    logic       exp_a [0:255];
    logic prev_any = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    i2c_bus_monitor u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .evt_start(evt_start), .evt_rep_start(evt_rep_start), .evt_stop(evt_stop),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ack(byte_ack),
        .proto_err(proto_err), .bus_idle(bus_idle)
    );

    always @(posedge clk) pcyc <= pcyc + 1;

    // Event monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (evt_start) begin got_start++; last_start_cyc = pcyc; end
            if (evt_rep_start) got_rep++;
            if (evt_stop) got_stop++;
            if (byte_valid) begin
                got_d[got_n[7:0]] = byte_data;
                got_a[got_n[7:0]] = byte_ack;
                got_n++;
            end
            if ((32'(evt_start) + 32'(evt_rep_start) + 32'(evt_stop) + 32'(byte_valid)) > 1) multi++;
            if (prev_any && (evt_start || evt_rep_start || evt_stop || byte_valid)) doubles++;
            prev_any = evt_start | evt_rep_start | evt_stop | byte_valid;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected strobe kind for a falling data edge in clock-high.
    function automatic bit exp_is_rep(bit in_xfer);
        return in_xfer;
    endfunction

    // Expected line level for bit position i (MSB first) of a byte.
    function automatic bit exp_bit(logic [7:0] d, int i);
        return d[7 - i];
    endfunction

    task automatic wq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_start(bit in_xfer);
        int t0;
        if (in_xfer) begin
            sda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
        end
        t0 = pcyc;
        sda = 1'b0;
        if (exp_is_rep(in_xfer)) exp_rep++; else exp_start++;
        wq(2 * Q);
        if (!in_xfer && exp_start == 1)
            chk(last_start_cyc - t0 == 3, "R2", "start latency", last_start_cyc - t0, 3);
        scl = 1'b0; wq(Q);
    endtask

    task automatic send_bit(bit b);
        sda = b; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(logic [7:0] d, bit a);
        for (int i = 0; i < 8; i++) send_bit(exp_bit(d, i));
        send_bit(a);
        exp_d[exp_n[7:0]] = d;
        exp_a[exp_n[7:0]] = a;
        exp_n++;
    endtask

    task automatic send_stop();
        sda = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda = 1'b1; wq(2 * Q);
        exp_stop++;
    endtask

    task automatic compare_all(string tag);
        chk(got_start == exp_start, "R2", {tag, " starts"}, got_start, exp_start);
        chk(got_rep == exp_rep, "R3", {tag, " repeated starts"}, got_rep, exp_rep);
        chk(got_stop == exp_stop, "R4", {tag, " stops"}, got_stop, exp_stop);
        chk(got_n == exp_n, "R6", {tag, " byte count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            if (got_d[i[7:0]] !== exp_d[i[7:0]] || got_a[i[7:0]] !== exp_a[i[7:0]]) begin
                chk(1'b0, "R5", {tag, " byte data"}, int'(got_d[i[7:0]]), int'(exp_d[i[7:0]]));
                chk(got_a[i[7:0]] === exp_a[i[7:0]], "R6", {tag, " ack bit"},
                    int'(got_a[i[7:0]]), int'(exp_a[i[7:0]]));
            end
        end
        chk(proto_err == 1'b0, "R7", {tag, " no error on clean traffic"}, int'(proto_err), 0);
        chk(bus_idle == 1'b1, "R4", {tag, " idle after stop"}, int'(bus_idle), 1);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        wq(4);
        rst_n = 1'b1;
        wq(4);
        // R1 reset state
        chk(!evt_start && !evt_rep_start && !evt_stop && !byte_valid, "R1", "strobes low", 0, 0);
        chk(proto_err == 1'b0, "R1", "error low", int'(proto_err), 0);
        chk(bus_idle == 1'b1, "R1", "idle high", int'(bus_idle), 1);

        // R9 clocks with no transfer active
        for (int i = 0; i < 9; i++) begin
            scl = 1'b0; wq(Q); scl = 1'b1; wq(Q);
        end
        wq(Q);
        chk(got_n == 0, "R9", "no byte outside transfer", got_n, 0);
        chk(got_start == 0, "R9", "no start from clocking", got_start, 0);

        // Directed corner bytes
        send_start(1'b0);
        send_byte(8'h80, 1'b1);
        send_byte(8'h01, 1'b0);
        send_stop();
        compare_all("directed");

        // Constrained random transfers, optionally with a repeated start
        for (int t = 0; t < 20; t++) begin
            int nb;
            nb = 1 + int'($urandom_range(2));
            send_start(1'b0);
            for (int b = 0; b < nb; b++)
                send_byte(8'($urandom_range(255)), 1'($urandom_range(1)));
            if ($urandom_range(1) == 1) begin
                send_start(1'b1);
                send_byte(8'($urandom_range(255)), 1'($urandom_range(1)));
            end
            send_stop();
            compare_all("random");
        end

        // R7 data moves mid-byte while clock is high
        begin
            int s0, p0;
            send_start(1'b0);
            s0 = got_start + got_rep; p0 = got_stop;
            send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
            sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
            chk(proto_err == 1'b1, "R7", "error set by glitch", int'(proto_err), 1);
            chk(got_start + got_rep == s0, "R7", "glitch not a start", got_start + got_rep, s0);
            sda = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda = 1'b1; wq(2 * Q);
            chk(got_stop == p0, "R7", "mid-byte rise not a stop", got_stop, p0);
            chk(proto_err == 1'b1, "R7", "error sticky", int'(proto_err), 1);
        end

        // R1 reset clears the error
        @(negedge clk); rst_n = 1'b0; wq(3); rst_n = 1'b1; wq(4);
        chk(proto_err == 1'b0, "R1", "error cleared by reset", int'(proto_err), 0);
        chk(bus_idle == 1'b1, "R1", "idle after reset", int'(bus_idle), 1);

        // R8 single-cycle exclusive strobes
        chk(multi == 0, "R8", "overlapping strobes", multi, 0);
        chk(doubles == 0, "R8", "back-to-back strobes", doubles, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule